// File: doc/BRIEF.md
# Affine positional mask select unit

This unit streams a two-dimensional tensor from input to output. Rows are channels and columns are elements. Each output word is either the input word at the same position or a programmable fill word. The choice depends only on the element's position. For each element the unit forms a mask value: a signed base, plus each loop index times a signed slope, plus the channel number times a signed per-channel multiplier. It then tests that value against zero using one of four comparisons. The data itself is never compared, and no predicate is read from anywhere. A single pass can therefore apply a triangular (causal) or band mask.

Software first sets the configuration inputs, then pulses `start`. The element space of one channel runs over up to four nested loops. Their counts multiply to the number of elements per channel. Words enter on a valid/ready stream and leave in the same order on a valid/ready stream. A one-cycle pulse marks the end of the run. The configuration inputs must stay unchanged from `start` until `done`.

Top module: `affine_mask_select`

## Requirements
- R1: After reset, `out_valid`, `in_ready`, `done` and `start_err` are all 0.
- R2: Output word j equals input word j when the test on its mask value is true, and equals the fill word otherwise. Words keep their order, and none is dropped or repeated.
- R3: For element k of channel c, the loop indices come from k with loop 0 innermost: i0 = k mod n0, i1 = (k / n0) mod n1, and so on. The mask is base + Σ i_d·step_d + c·chan_mult, evaluated in 40-bit signed arithmetic. Base and chan_mult are signed 32-bit, and each step is signed 16-bit, packed at bits [16d+15:16d] of `cfg_step`. Counts are packed the same way in `cfg_count`.
- R4: `cfg_cmp` selects the test against zero: 0 = greater-than, 1 = greater-or-equal, 2 = equal, 3 = not-equal.
- R5: Channels 0 to `cfg_num_chan`-1 are processed in order. Each applies its own c·chan_mult offset. Up to 128 channels are supported.
- R6: A `start` is rejected if any of these holds: the product of the four counts differs from `cfg_num_elem`, `cfg_num_elem` is 0, or `cfg_num_chan` is outside 1..128. A rejected start produces a one-cycle `start_err` pulse one cycle later and no run, so `in_ready` stays 0.
- R7: With `cfg_int_out` = 0, the fill word is output bit for bit as FP32. With `cfg_int_out` = 1, the FP32 fill is converted to INT32 by truncating toward zero. Magnitudes beyond the signed range saturate (infinities included), and NaN gives 0. Input words always pass through unchanged.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value. Mask generation stalls without losing its place.
- R9: `done` is 1 for exactly the cycle after the output handshake of the last element of the last channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start a run with the current configuration |
| cfg_base | input | 32 | Signed mask base |
| cfg_step | input | 64 | Four signed 16-bit slopes, loop 0 in the low bits |
| cfg_count | input | 64 | Four unsigned 16-bit loop counts, loop 0 in the low bits |
| cfg_chan_mult | input | 32 | Signed per-channel mask offset |
| cfg_num_chan | input | 8 | Number of active channels |
| cfg_num_elem | input | 32 | Elements per channel |
| cfg_cmp | input | 2 | Comparison code against zero |
| cfg_fill | input | 32 | FP32 fill value |
| cfg_int_out | input | 1 | 1 selects INT32 output format for the fill |
| start_err | output | 1 | Pulse: start rejected |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when valid |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 32 | Output word |
| done | output | 1 | Pulse: run finished |

## Verification
The bench targets loop wrap-around in several configurations: a single wide loop, two loops with slopes of opposite sign, and four loops of extent 2. A generator that subtracted the wrong accumulated term, or that failed to carry into the outer loop, would put the triangle or band edge in the wrong column. Extreme base, slope and multiplier values across all 128 channels expose a 32-bit accumulator, because the sign test flips after wrap-around. Stalls on the output and gaps on the input test whether the mask stays aligned with the data under stalls. If it does not, words are shifted, duplicated or dropped. The INT32 fill cases cover a fraction below one, a negative fraction, and both saturation limits. These catch rounding in place of truncation, or a missing clamp.

// File: rtl/amsel_pkg.sv
// Shared types for the affine mask select unit.
// Assumes: comparison code encoding is fixed by the requirements.
package amsel_pkg;
    typedef enum logic [1:0] {
        CMP_GT = 2'd0,
        CMP_GE = 2'd1,
        CMP_EQ = 2'd2,
        CMP_NE = 2'd3
    } cmp_code_e;
endpackage

// File: rtl/amsel_ramp.sv
// Incremental affine mask generator.
// Keeps loop indices, per-loop accumulated contributions and the running
// mask value; one advance per accepted element, no per-element multiply.
// Assumes: configuration is static while active; every count is >= 1.
module amsel_ramp #(
    parameter int NDIM   = 4,
    parameter int CNT_W  = 16,
    parameter int STEP_W = 16,
    parameter int MASK_W = 40,
    parameter int CH_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    adv,
    input  logic                    active,
    input  logic [31:0]             base,
    input  logic [NDIM*STEP_W-1:0]  step,
    input  logic [NDIM*CNT_W-1:0]   count,
    input  logic [31:0]             mult,
    input  logic [CH_W-1:0]         num_chan,
    output logic [MASK_W-1:0]       mask,
    output logic                    last_elem,
    output logic                    last_chan
);
    logic signed [MASK_W-1:0] base_x, mult_x;
    logic signed [MASK_W-1:0] stp_x [NDIM];
    logic        [CNT_W-1:0]  cnt_m1 [NDIM];

    logic        [CNT_W-1:0]  idx_q [NDIM];
    logic signed [MASK_W-1:0] acc_q [NDIM];
    logic signed [MASK_W-1:0] mask_q, off_q;
    logic        [CH_W-1:0]   chan_q;

    logic        [CNT_W-1:0]  idx_n [NDIM];
    logic signed [MASK_W-1:0] acc_n [NDIM];
    logic signed [MASK_W-1:0] mask_n, off_n;
    logic        [CH_W-1:0]   chan_n;

    assign base_x = MASK_W'($signed(base));
    assign mult_x = MASK_W'($signed(mult));

    // Unpack per-loop slopes and last-index values.
    for (genvar d = 0; d < NDIM; d++) begin : g_unpack
        assign stp_x[d]  = MASK_W'($signed(step[d*STEP_W +: STEP_W]));
        assign cnt_m1[d] = count[d*CNT_W +: CNT_W] - CNT_W'(1);
    end

    // Flag the final element of a channel and the final channel.
    always_comb begin
        last_elem = 1'b1;
        for (int d = 0; d < NDIM; d++) begin
            if (idx_q[d] != cnt_m1[d]) last_elem = 1'b0;
        end
        last_chan = (chan_q == num_chan - CH_W'(1));
    end

    // Next-state ramp: odometer carry chain with subtract-on-wrap.
    always_comb begin
        logic carry;
        carry  = 1'b1;
        mask_n = mask_q;
        off_n  = off_q;
        chan_n = chan_q;
        for (int d = 0; d < NDIM; d++) begin
            idx_n[d] = idx_q[d];
            acc_n[d] = acc_q[d];
            if (carry) begin
                if (idx_q[d] != cnt_m1[d]) begin
                    idx_n[d] = idx_q[d] + CNT_W'(1);
                    acc_n[d] = acc_q[d] + stp_x[d];
                    mask_n   = mask_n + stp_x[d];
                    carry    = 1'b0;
                end else begin
                    idx_n[d] = '0;
                    acc_n[d] = '0;
                    mask_n   = mask_n - acc_q[d];
                end
            end
        end
        if (carry) begin
            chan_n = chan_q + CH_W'(1);
            off_n  = off_q + mult_x;
            mask_n = base_x + off_q + mult_x;
        end
    end

    // Ramp state registers: cleared on load, stepped on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            for (int d = 0; d < NDIM; d++) begin
                idx_q[d] <= '0;
                acc_q[d] <= '0;
            end
            mask_q <= rst_n ? base_x : '0;
            off_q  <= '0;
            chan_q <= '0;
        end else if (adv) begin
            for (int d = 0; d < NDIM; d++) begin
                idx_q[d] <= idx_n[d];
                acc_q[d] <= acc_n[d];
            end
            mask_q <= mask_n;
            off_q  <= off_n;
            chan_q <= chan_n;
        end
    end

    assign mask = mask_q;

    logic row_start;
    always_comb begin
        row_start = 1'b1;
        for (int d = 0; d < NDIM; d++) begin
            if (idx_q[d] != '0) row_start = 1'b0;
        end
    end

    // R3: at the first element of each channel the mask is base plus channel offset.
    a_r3_row_start: assert property (@(posedge clk) disable iff (!rst_n)
        active && row_start |-> mask_q == base_x + off_q);

    // R5: the channel counter never passes the configured channel count.
    a_r5_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> chan_q < num_chan);
endmodule

// File: rtl/amsel_cmp.sv
// Sign/zero test of the mask value against the constant zero.
// Assumes: mask is two's complement of MASK_W bits.
module amsel_cmp #(
    parameter int MASK_W = 40
) (
    input  logic [MASK_W-1:0] mask,
    input  logic [1:0]        code,
    output logic              pass
);
    import amsel_pkg::*;

    logic neg, zero;
    assign neg  = mask[MASK_W-1];
    assign zero = (mask == '0);

    // Select the test named by the comparison code.
    always_comb begin
        unique case (cmp_code_e'(code))
            CMP_GT:  pass = !neg && !zero;
            CMP_GE:  pass = !neg;
            CMP_EQ:  pass = zero;
            default: pass = !zero;
        endcase
    end
endmodule

// File: rtl/amsel_fill_cvt.sv
// Converts the FP32 fill word to the output format.
// FP32 mode passes bits; INT32 mode truncates toward zero, saturates,
// and maps NaN to zero. Assumes fill is static during a run.
module amsel_fill_cvt (
    input  logic [31:0] fill,
    input  logic        int_out,
    output logic [31:0] word
);
    logic        sgn;
    logic [7:0]  ex;
    logic [23:0] man;
    logic [4:0]  sh;
    logic [30:0] mag;
    logic [31:0] ival;

    assign sgn = fill[31];
    assign ex  = fill[30:23];
    assign man = {1'b1, fill[22:0]};
    assign sh  = 5'(ex - 8'd127);

    // Integer conversion with truncation and clamping.
    always_comb begin
        mag  = '0;
        ival = '0;
        if (ex == 8'hFF && fill[22:0] != '0) begin
            ival = '0;
        end else if (ex >= 8'd158) begin
            ival = sgn ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end else if (ex >= 8'd127) begin
            if (sh >= 5'd23) mag = 31'(man) << (sh - 5'd23);
            else             mag = 31'(man >> (5'd23 - sh));
            ival = sgn ? -{1'b0, mag} : {1'b0, mag};
        end
    end

    assign word = int_out ? ival : fill;
endmodule

// File: rtl/affine_mask_select.sv
// Affine positional mask select unit (top).
// Checks the configuration at start, runs the mask ramp in step with
// accepted input words, and registers one output word per element.
// Assumes: cfg_* inputs are static from start until done.
module affine_mask_select #(
    parameter int NDIM   = 4,
    parameter int CNT_W  = 16,
    parameter int STEP_W = 16,
    parameter int MASK_W = 40,
    parameter int MAX_CH = 128,
    parameter int ELEM_W = 32,
    localparam int CH_W   = $clog2(MAX_CH + 1),
    localparam int PROD_W = NDIM * CNT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [31:0]            cfg_base,
    input  logic [NDIM*STEP_W-1:0] cfg_step,
    input  logic [NDIM*CNT_W-1:0]  cfg_count,
    input  logic [31:0]            cfg_chan_mult,
    input  logic [CH_W-1:0]        cfg_num_chan,
    input  logic [ELEM_W-1:0]      cfg_num_elem,
    input  logic [1:0]             cfg_cmp,
    input  logic [31:0]            cfg_fill,
    input  logic                   cfg_int_out,
    output logic                   start_err,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [31:0]            in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [31:0]            out_data,
    output logic                   done
);
    logic              running;
    logic              cfg_ok;
    logic [PROD_W-1:0] prod;
    logic              load, accept;
    logic [MASK_W-1:0] mask;
    logic              last_elem, last_chan, pass;
    logic [31:0]       fill_word;
    logic              out_last;

    // Start-time legality: count product, element count and channel range.
    always_comb begin
        prod = PROD_W'(1);
        for (int d = 0; d < NDIM; d++) begin
            prod = PROD_W'(prod * PROD_W'(cfg_count[d*CNT_W +: CNT_W]));
        end
        cfg_ok = (prod == PROD_W'(cfg_num_elem)) && (cfg_num_elem != '0)
              && (cfg_num_chan != '0) && (cfg_num_chan <= CH_W'(MAX_CH));
    end

    assign load     = start && !running && cfg_ok;
    assign in_ready = running && (!out_valid || out_ready);
    assign accept   = in_valid && in_ready;

    amsel_ramp #(
        .NDIM(NDIM), .CNT_W(CNT_W), .STEP_W(STEP_W),
        .MASK_W(MASK_W), .CH_W(CH_W)
    ) u_ramp (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(accept),
        .active(running), .base(cfg_base), .step(cfg_step),
        .count(cfg_count), .mult(cfg_chan_mult), .num_chan(cfg_num_chan),
        .mask(mask), .last_elem(last_elem), .last_chan(last_chan)
    );

    amsel_cmp #(.MASK_W(MASK_W)) u_cmp (
        .mask(mask), .code(cfg_cmp), .pass(pass)
    );

    amsel_fill_cvt u_fill (
        .fill(cfg_fill), .int_out(cfg_int_out), .word(fill_word)
    );

    // Run control: enter on a legal start, leave after the final element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            start_err <= 1'b0;
        end else begin
            start_err <= start && !running && !cfg_ok;
            if (load)
                running <= 1'b1;
            else if (accept && last_elem && last_chan)
                running <= 1'b0;
        end
    end

    // Output register: capture the selected word on each accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= pass ? in_data : fill_word;
            out_last  <= last_elem && last_chan;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Completion pulse after the final output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= out_valid && out_ready && out_last;
    end

    // R8: a stalled output word stays valid and unchanged.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9: done only follows an output handshake.
    a_r9_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready));

    // R6: a rejected start leaves the input closed.
    a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |-> !in_ready);
endmodule

// File: tb/tb_affine_mask_select.sv
// Directed bench: one task per scenario, each checking its own outputs.
module tb_affine_mask_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [63:0] cfg_step = '0;
    logic [63:0] cfg_count = '0;
    logic [31:0] cfg_chan_mult = '0;
    logic [7:0]  cfg_num_chan = '0;
    logic [31:0] cfg_num_elem = '0;
    logic [1:0]  cfg_cmp = '0;
    logic [31:0] cfg_fill = '0;
    logic        cfg_int_out = 1'b0;
    logic        start_err;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    affine_mask_select dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_step(cfg_step), .cfg_count(cfg_count), .cfg_chan_mult(cfg_chan_mult),
        .cfg_num_chan(cfg_num_chan), .cfg_num_elem(cfg_num_elem), .cfg_cmp(cfg_cmp),
        .cfg_fill(cfg_fill), .cfg_int_out(cfg_int_out), .start_err(start_err),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] datagen(input int j);
        return 32'h5A00_0000 ^ (j * 37 + 11);
    endfunction

    // Expected output j from the requirements (R2, R3, R4, R5).
    function automatic logic [31:0] expect_word(input int j, input int ne,
            input logic [31:0] base, input logic [63:0] steps, input logic [63:0] cnts,
            input logic [31:0] mult, input logic [1:0] code, input logic [31:0] fexp);
        int c, rem;
        longint m;
        bit p;
        c   = j / ne;
        rem = j % ne;
        m   = longint'($signed(base)) + longint'(c) * longint'($signed(mult));
        for (int d = 0; d < 4; d++) begin
            int n, i;
            n   = int'(cnts[d*16 +: 16]);
            i   = rem % n;
            rem = rem / n;
            m   = m + longint'(i) * longint'($signed(steps[d*16 +: 16]));
        end
        case (code)
            2'd0: p = m > 0;
            2'd1: p = m >= 0;
            2'd2: p = m == 0;
            default: p = m != 0;
        endcase
        return p ? datagen(j) : fexp;
    endfunction

    task automatic run_case(input string req, input logic [31:0] base, input logic [63:0] steps,
            input logic [63:0] cnts, input logic [31:0] mult, input int nch, input logic [1:0] code,
            input logic [31:0] fill, input logic iint, input logic [31:0] fexp,
            input int rmod, input int gmod);
        int ne, total, ni, no, cyc;
        bit pend;
        logic [31:0] hold;
        ne = 1;
        for (int d = 0; d < 4; d++) ne = ne * int'(cnts[d*16 +: 16]);
        total = ne * nch;
        @(negedge clk);
        cfg_base = base; cfg_step = steps; cfg_count = cnts; cfg_chan_mult = mult;
        cfg_num_chan = 8'(nch); cfg_num_elem = 32'(ne); cfg_cmp = code;
        cfg_fill = fill; cfg_int_out = iint; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(start_err == 1'b0, {req, " R6 legal start accepted"}, 32'(start_err), 32'd0);
        ni = 0; no = 0; cyc = 0; pend = 0; hold = '0;
        while (no < total && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (pend) begin
                chk(out_valid && out_data == hold, {req, " R8 stalled word held"}, out_data, hold);
            end
            in_valid  = (ni < total) && (gmod == 0 || (cyc % gmod) != 0);
            in_data   = datagen(ni);
            out_ready = (rmod == 0) || ((cyc % rmod) != 0);
            #1;
            if (in_valid && in_ready) ni++;
            pend = out_valid && !out_ready;
            hold = out_data;
            if (out_valid && out_ready) begin
                logic [31:0] e;
                e = expect_word(no, ne, base, steps, cnts, mult, code, fexp);
                chk(out_data == e, {req, " R2 output word"}, out_data, e);
                no++;
            end
        end
        chk(no == total, {req, " R2 word count"}, 32'(no), 32'(total));
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        chk(done == 1'b1, {req, " R9 done after last handshake"}, 32'(done), 32'd1);
        @(negedge clk);
        chk(done == 1'b0, {req, " R9 done is one cycle"}, 32'(done), 32'd0);
    endtask

    task automatic test_reset();
        chk(out_valid == 0 && in_ready == 0 && done == 0 && start_err == 0,
            "R1 reset state", {out_valid, in_ready, done, start_err}, 32'd0);
    endtask

    task automatic try_reject(input string req, input logic [63:0] cnts, input int ne, input int nch);
        @(negedge clk);
        cfg_count = cnts; cfg_num_elem = 32'(ne); cfg_num_chan = 8'(nch);
        start = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(start_err == 1'b1, {req, " R6 start_err pulse"}, 32'(start_err), 32'd1);
        chk(in_ready == 1'b0, {req, " R6 no run after reject"}, 32'(in_ready), 32'd0);
        @(negedge clk);
        chk(start_err == 1'b0 && in_ready == 1'b0, {req, " R6 single pulse, still idle"},
            {start_err, in_ready}, 32'd0);
        in_valid = 1'b0;
    endtask

    task automatic test_reject();
        try_reject("R6 product", {16'd1, 16'd1, 16'd2, 16'd3}, 5, 1);
        try_reject("R6 zero elems", {16'd1, 16'd1, 16'd0, 16'd3}, 0, 1);
        try_reject("R6 zero chans", {16'd1, 16'd1, 16'd1, 16'd4}, 4, 0);
        try_reject("R6 too many chans", {16'd1, 16'd1, 16'd1, 16'd4}, 4, 129);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // R4 R5 upper triangle: mask = k - c, greater-or-equal.
        run_case("R4 triangle GE", 32'd0, {16'd0, 16'd0, 16'd0, 16'd1},
                 {16'd1, 16'd1, 16'd1, 16'd4}, 32'hFFFF_FFFF, 4, 2'd1,
                 32'hFF80_0000, 1'b0, 32'hFF80_0000, 0, 0);
        // R3 two loops with opposite slopes, GT, output stalls.
        run_case("R3 two loops GT stall", 32'd1, {16'd0, 16'd0, 16'hFFFB, 16'd2},
                 {16'd1, 16'd1, 16'd2, 16'd3}, 32'd3, 3, 2'd0,
                 32'h3F80_0000, 1'b0, 32'h3F80_0000, 3, 0);
        // R4 band on equality, input gaps.
        run_case("R4 band EQ gaps", 32'hFFFF_FFFE, {16'd0, 16'd0, 16'd0, 16'd1},
                 {16'd1, 16'd1, 16'd1, 16'd6}, 32'd1, 5, 2'd2,
                 32'h0000_0000, 1'b0, 32'h0000_0000, 0, 3);
        // R3 four loops, not-equal, stalls and gaps.
        run_case("R3 four loops NE", 32'hFFFF_FFFD, {16'hFFF8, 16'd4, 16'hFFFE, 16'd1},
                 {16'd2, 16'd2, 16'd2, 16'd2}, 32'd7, 2, 2'd3,
                 32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF, 2, 4);
        // R3 R5 wide values over 128 channels, GT all pass.
        run_case("R3 wide positive 128ch", 32'h7FFF_FFFF, {16'd0, 16'd0, 16'd0, 16'h7FFF},
                 {16'd1, 16'd1, 16'd1, 16'd2}, 32'h7FFF_FFFF, 128, 2'd0,
                 32'h1234_5678, 1'b0, 32'h1234_5678, 0, 0);
        // R3 wide negative values, GE all fail.
        run_case("R3 wide negative", 32'h8000_0000, {16'd0, 16'd0, 16'd0, 16'h8000},
                 {16'd1, 16'd1, 16'd1, 16'd2}, 32'h8000_0000, 128, 2'd1,
                 32'h8765_4321, 1'b0, 32'h8765_4321, 0, 0);
        // R7 INT32 fill conversion; mask is -1 everywhere, GT fails.
        run_case("R7 int -3.75", 32'hFFFF_FFFF, 64'd0, {16'd1, 16'd1, 16'd1, 16'd2},
                 32'd0, 1, 2'd0, 32'hC070_0000, 1'b1, 32'hFFFF_FFFD, 0, 0);
        run_case("R7 int 0.5", 32'hFFFF_FFFF, 64'd0, {16'd1, 16'd1, 16'd1, 16'd2},
                 32'd0, 1, 2'd0, 32'h3F00_0000, 1'b1, 32'h0000_0000, 0, 0);
        run_case("R7 int sat high", 32'hFFFF_FFFF, 64'd0, {16'd1, 16'd1, 16'd1, 16'd2},
                 32'd0, 1, 2'd0, 32'h4F32_D05E, 1'b1, 32'h7FFF_FFFF, 0, 0);
        run_case("R7 int sat low", 32'hFFFF_FFFF, 64'd0, {16'd1, 16'd1, 16'd1, 16'd2},
                 32'd0, 1, 2'd0, 32'hD015_02F9, 1'b1, 32'h8000_0000, 0, 0);
        run_case("R7 int 100", 32'hFFFF_FFFF, 64'd0, {16'd1, 16'd1, 16'd1, 16'd2},
                 32'd0, 1, 2'd0, 32'h42C8_0000, 1'b1, 32'h0000_0064, 0, 0);
        test_reject();
        // R6 a legal run still works after rejects.
        run_case("R6 after reject", 32'd0, {16'd0, 16'd0, 16'd0, 16'd1},
                 {16'd1, 16'd1, 16'd2, 16'd3}, 32'hFFFF_FFFE, 2, 2'd0,
                 32'hCAFE_F00D, 1'b0, 32'hCAFE_F00D, 2, 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule